// File: doc/BRIEF.md
# APB Nibble-Select Address Decoder

This block sits between one APB requester and up to sixteen APB completer ports. A single 4-bit field of the requester's address chooses the destination port, and the position of that field is a parameter. The decoder raises the select line of that port only. It sends the address, write strobe, enable and write data to the ports unchanged, and it routes the chosen port's read data, ready and error back to the requester.

A parameter mask lists the ports that are populated. A transfer aimed at an unpopulated port selects no port. The decoder ends that transfer itself, with ready high, error high and read data zero.

Instances can be chained to build a layered address map. An upper instance may decode bits [27:24], and each of its ports may feed a lower instance that decodes bits [23:20]. With the default settings (field at bit 20, six ports populated), offset 0x0010_0000 reaches port 1 and offset 0x0050_0000 reaches port 5.

Top module: `apb_nibble_decoder`

## Requirements
- R1: The value n of address bits [SEL_LSB+3:SEL_LSB] (default SEL_LSB = 20) selects port n. Address 0x0010_0000 reaches port 1 and 0x0050_0000 reaches port 5.
- R2: At most one bit of `slv_psel` is ever high. When `mst_psel` is low, every bit of `slv_psel` is low.
- R3: The select line of the chosen port is high during the setup cycle and in every access cycle. It stays unchanged until the chosen port returns ready, so wait states are honoured.
- R4: `slv_paddr`, `slv_pwrite`, `slv_penable` and `slv_pwdata` equal the requester's address, write strobe, enable and write data.
- R5: While a port is selected, `mst_prdata`, `mst_pready` and `mst_pslverr` equal that port's read data, ready and error inputs.
- R6: Bit n of PORT_MASK marks port n as present (default 16'h003F, ports 0 to 5). An access to an absent port raises no select line, returns ready 1, error 1 and read data 0, and changes no port's state.
- R7: Address bits above the select field are not decoded. Addresses 0xF140_0004 and 0x0040_0008 reach the same port, port 4.
- R8: After a transfer ends, the return path keeps the port of that transfer while `mst_psel` stays low, even if the address changes.
- R9: During reset, and in the idle cycles after it, no select line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_paddr | input | ADDR_W | Requester address |
| mst_psel | input | 1 | Requester select |
| mst_penable | input | 1 | Requester enable (access phase) |
| mst_pwrite | input | 1 | Requester write strobe |
| mst_pwdata | input | DATA_W | Requester write data |
| mst_prdata | output | DATA_W | Read data returned to the requester |
| mst_pready | output | 1 | Ready returned to the requester |
| mst_pslverr | output | 1 | Error returned to the requester |
| slv_paddr | output | ADDR_W | Address sent to all ports |
| slv_psel | output | 16 | One select line per port |
| slv_penable | output | 1 | Enable sent to all ports |
| slv_pwrite | output | 1 | Write strobe sent to all ports |
| slv_pwdata | output | DATA_W | Write data sent to all ports |
| slv_prdata | input | 16*DATA_W | Read data of all ports, port n at bits [n*DATA_W +: DATA_W] |
| slv_pready | input | 16 | Ready of each port |
| slv_pslverr | input | 16 | Error of each port |

## Verification
The assertions check on every cycle that at most one select line is high, and that no select line is high while the requester is idle or when the line belongs to an absent port. They also check that the select stays unchanged through setup and wait states, that the return path matches the selected port, and that an absent-port access ends with ready and error high and data zero.

Some behaviours need a reference outside the decoder, and only the bench scenarios show them:
- that a given address reaches the intended port number;
- that high address bits are ignored;
- that data written through one port reads back through the same port;
- that a write to an absent port leaves every populated port untouched;
- that the idle return path keeps its value while the address moves.

// File: rtl/apb_dec_pkg.sv
// Package: shared constants, types and helpers for the nibble-select APB decoder.
// Assumes a 4-bit select field, so the port count is fixed at 16.
package apb_dec_pkg;
    localparam int SEL_W = 4;
    localparam int NPORT = 1 << SEL_W;

    typedef logic [SEL_W-1:0] port_idx_t;
    typedef logic [NPORT-1:0] port_vec_t;

    // One-hot vector with only bit idx set.
    function automatic port_vec_t idx_to_onehot(input port_idx_t idx);
        port_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/apb_dec_select.sv
// Module: apb_dec_select
// Works out which port a transfer targets and drives the per-port select lines.
// In the setup cycle the live address nibble is used, and it is captured there.
// Every later cycle uses the captured nibble, so the select and the return path
// stay steady through wait states and after the transfer ends.
// Assumes the requester follows APB phase order (setup, then access).
module apb_dec_select
    import apb_dec_pkg::*;
#(
    parameter port_vec_t PORT_MASK = 16'h003F
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mst_psel,
    input  logic      mst_penable,
    input  port_idx_t live_idx,
    output port_idx_t eff_idx,
    output logic      port_hit,
    output port_vec_t slv_psel
);
    port_idx_t held_idx;
    logic      setup_phase;

    // Marks the first cycle of a transfer.
    assign setup_phase = mst_psel && !mst_penable;

    // Captures the target nibble in the setup cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_idx <= '0;
        end else if (setup_phase) begin
            held_idx <= live_idx;
        end
    end

    // Chooses the nibble in force and decodes it against the presence mask.
    always_comb begin
        eff_idx  = setup_phase ? live_idx : held_idx;
        port_hit = PORT_MASK[eff_idx];
        if (mst_psel && port_hit) begin
            slv_psel = idx_to_onehot(eff_idx);
        end else begin
            slv_psel = '0;
        end
    end
endmodule

// File: rtl/apb_dec_retmux.sv
// Module: apb_dec_retmux
// Return-path multiplexer. It routes read data, ready and error from the port
// in force back to the requester. For an absent port it gives ready 1, error 1
// and data 0. Assumes a flat read-data bus with port n at [n*DATA_W +: DATA_W].
module apb_dec_retmux
    import apb_dec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  port_idx_t                eff_idx,
    input  logic                     port_hit,
    input  logic [NPORT*DATA_W-1:0]  slv_prdata,
    input  port_vec_t                slv_pready,
    input  port_vec_t                slv_pslverr,
    output logic [DATA_W-1:0]        mst_prdata,
    output logic                     mst_pready,
    output logic                     mst_pslverr
);
    logic [DATA_W-1:0] rd_arr [NPORT];

    // Splits the flat read-data bus into one word per port.
    for (genvar g = 0; g < NPORT; g++) begin : g_unpack
        assign rd_arr[g] = slv_prdata[g*DATA_W +: DATA_W];
    end

    // Chooses the response source: a present port, or the built-in error reply.
    always_comb begin
        if (port_hit) begin
            mst_prdata  = rd_arr[eff_idx];
            mst_pready  = slv_pready[eff_idx];
            mst_pslverr = slv_pslverr[eff_idx];
        end else begin
            mst_prdata  = '0;
            mst_pready  = 1'b1;
            mst_pslverr = 1'b1;
        end
    end
endmodule

// File: rtl/apb_nibble_decoder.sv
// Module: apb_nibble_decoder (top)
// Fans one APB requester out to sixteen completer ports. Address bits
// [SEL_LSB+3:SEL_LSB] choose the port, and PORT_MASK lists the ports present.
// Address, write strobe, enable and write data go to all ports; only the
// select line is per port. Assumes SEL_LSB + 4 <= ADDR_W.
module apb_nibble_decoder
    import apb_dec_pkg::*;
#(
    parameter int        ADDR_W    = 32,
    parameter int        DATA_W    = 32,
    parameter int        SEL_LSB   = 20,
    parameter port_vec_t PORT_MASK = 16'h003F
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        mst_paddr,
    input  logic                     mst_psel,
    input  logic                     mst_penable,
    input  logic                     mst_pwrite,
    input  logic [DATA_W-1:0]        mst_pwdata,
    output logic [DATA_W-1:0]        mst_prdata,
    output logic                     mst_pready,
    output logic                     mst_pslverr,
    output logic [ADDR_W-1:0]        slv_paddr,
    output logic [NPORT-1:0]         slv_psel,
    output logic                     slv_penable,
    output logic                     slv_pwrite,
    output logic [DATA_W-1:0]        slv_pwdata,
    input  logic [NPORT*DATA_W-1:0]  slv_prdata,
    input  logic [NPORT-1:0]         slv_pready,
    input  logic [NPORT-1:0]         slv_pslverr
);
    port_idx_t live_idx;
    port_idx_t eff_idx;
    logic      port_hit;

    // Takes the select field out of the requester address.
    assign live_idx = mst_paddr[SEL_LSB +: SEL_W];

    // Sends the shared request signals to every port unchanged.
    assign slv_paddr   = mst_paddr;
    assign slv_penable = mst_penable;
    assign slv_pwrite  = mst_pwrite;
    assign slv_pwdata  = mst_pwdata;

    apb_dec_select #(
        .PORT_MASK (PORT_MASK)
    ) u_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .mst_psel    (mst_psel),
        .mst_penable (mst_penable),
        .live_idx    (live_idx),
        .eff_idx     (eff_idx),
        .port_hit    (port_hit),
        .slv_psel    (slv_psel)
    );

    apb_dec_retmux #(
        .DATA_W (DATA_W)
    ) u_retmux (
        .eff_idx     (eff_idx),
        .port_hit    (port_hit),
        .slv_prdata  (slv_prdata),
        .slv_pready  (slv_pready),
        .slv_pslverr (slv_pslverr),
        .mst_prdata  (mst_prdata),
        .mst_pready  (mst_pready),
        .mst_pslverr (mst_pslverr)
    );
endmodule

// File: rtl/apb_nibble_decoder_chk.sv
// Module: apb_nibble_decoder_chk
// Protocol checker bound to apb_nibble_decoder. It only observes.
module apb_nibble_decoder_chk
    import apb_dec_pkg::*;
#(
    parameter int        DATA_W    = 32,
    parameter port_vec_t PORT_MASK = 16'h003F
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    mst_psel,
    input logic                    mst_penable,
    input logic [DATA_W-1:0]       mst_prdata,
    input logic                    mst_pready,
    input logic                    mst_pslverr,
    input logic [NPORT-1:0]        slv_psel,
    input logic [NPORT*DATA_W-1:0] slv_prdata,
    input logic [NPORT-1:0]        slv_pready,
    input logic [NPORT-1:0]        slv_pslverr
);
    // R2: never more than one port selected
    a_r2_psel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slv_psel));

    // R2: an idle requester selects no port
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mst_psel |-> (slv_psel == '0));

    // R3: the select holds through setup and wait states
    a_r3_psel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_psel && !(mst_penable && mst_pready)) |=> (!mst_psel || $stable(slv_psel)));

    // R6: only present ports are ever selected
    a_r6_mask_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((slv_psel & ~PORT_MASK) == '0));

    // R6: an absent target gets the built-in error reply
    a_r6_absent_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_psel && (slv_psel == '0)) |-> (mst_pready && mst_pslverr && (mst_prdata == '0)));

    // R5: the response follows the selected port
    for (genvar g = 0; g < NPORT; g++) begin : g_ret
        a_r5_return_path: assert property (@(posedge clk) disable iff (!rst_n)
            slv_psel[g] |-> ((mst_pready == slv_pready[g]) &&
                             (mst_pslverr == slv_pslverr[g]) &&
                             (mst_prdata == slv_prdata[g*DATA_W +: DATA_W])));
    end
endmodule

bind apb_nibble_decoder apb_nibble_decoder_chk #(
    .DATA_W    (DATA_W),
    .PORT_MASK (PORT_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mst_psel    (mst_psel),
    .mst_penable (mst_penable),
    .mst_prdata  (mst_prdata),
    .mst_pready  (mst_pready),
    .mst_pslverr (mst_pslverr),
    .slv_psel    (slv_psel),
    .slv_prdata  (slv_prdata),
    .slv_pready  (slv_pready),
    .slv_pslverr (slv_pslverr)
);

// File: tb/apb_nibble_decoder_tb.sv
`timescale 1ns/1ps
// Scoreboard bench. The driver task queues the expected response of each
// transfer; the monitor checks the design against it at each negedge.
module apb_nibble_decoder_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NP = 16;
    localparam logic [15:0] MASK = 16'h003F;

    typedef struct {
        logic [15:0] sel;
        logic [31:0] rdata;
        logic        err;
        logic        wr;
        int          waits;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] mst_prdata;
    logic mst_pready, mst_pslverr;
    logic [AW-1:0] slv_paddr;
    logic [NP-1:0] slv_psel;
    logic slv_penable, slv_pwrite;
    logic [DW-1:0] slv_pwdata;
    logic [NP*DW-1:0] slv_prdata;
    logic [NP-1:0] slv_pready, slv_pslverr;

    int n_cmp = 0, n_bad = 0;
    int wait_cfg = 0, wcnt = 0, seen_waits = 0;
    logic [31:0] exp_mem [NP];
    logic [31:0] wmem [NP];
    exp_t q[$];
    bit finished = 0;

    always #2 clk = ~clk;

    apb_nibble_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .mst_paddr(paddr), .mst_psel(psel),
        .mst_penable(penable), .mst_pwrite(pwrite), .mst_pwdata(pwdata),
        .mst_prdata(mst_prdata), .mst_pready(mst_pready), .mst_pslverr(mst_pslverr),
        .slv_paddr(slv_paddr), .slv_psel(slv_psel), .slv_penable(slv_penable),
        .slv_pwrite(slv_pwrite), .slv_pwdata(slv_pwdata), .slv_prdata(slv_prdata),
        .slv_pready(slv_pready), .slv_pslverr(slv_pslverr)
    );

    function automatic logic [31:0] pat(input int p);
        return 32'h1111_1111 * p;
    endfunction

    // Completer models: a storage word per port, a shared wait counter, and port 3 always reports an error.
    always_comb begin
        for (int i = 0; i < NP; i++) slv_prdata[i*DW +: DW] = wmem[i] ^ pat(i);
        slv_pready  = (wcnt >= wait_cfg) ? '1 : '0;
        slv_pslverr = 16'h0008;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= 0;
            for (int i = 0; i < NP; i++) wmem[i] <= '0;
        end else begin
            if ((slv_psel != 0) && slv_penable && !(wcnt >= wait_cfg)) wcnt <= wcnt + 1;
            else wcnt <= 0;
            for (int i = 0; i < NP; i++)
                if (slv_psel[i] && slv_penable && slv_pready[i] && slv_pwrite) wmem[i] <= slv_pwdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Driver: queues the expected result, then runs one APB transfer.
    task automatic xfer(input logic [31:0] addr, input bit wr, input logic [31:0] data,
                        input int waits, input string tag);
        exp_t e;
        int p;
        bit present;
        p = int'(addr[23:20]);
        present = MASK[p];
        e.sel   = present ? (16'h1 << p) : 16'h0;
        e.err   = !present || (p == 3);
        e.rdata = present ? (exp_mem[p] ^ pat(p)) : 32'h0;
        e.wr    = wr;
        e.waits = present ? waits : 0;
        e.tag   = tag;
        if (wr && present) exp_mem[p] = data;
        q.push_back(e);
        @(posedge clk); #1;
        wait_cfg = waits; paddr = addr; pwrite = wr; pwdata = data; psel = 1; penable = 0;
        @(posedge clk); #1;
        penable = 1;
        forever begin
            @(negedge clk);
            if (mst_pready) break;
        end
        @(posedge clk); #1;
        psel = 0; penable = 0;
    endtask

    // Monitor: checks setup, wait and completion cycles against the queue head.
    always @(negedge clk) begin
        if (rst_n && psel) begin
            if (q.size() == 0) begin
                chk("R2 unexpected transfer", 32'd1, 32'd0);
            end else if (!penable) begin
                chk({q[0].tag, " R3 setup select"}, 32'(slv_psel), 32'(q[0].sel));
                seen_waits = 0;
            end else if (!mst_pready) begin
                chk({q[0].tag, " R3 wait select"}, 32'(slv_psel), 32'(q[0].sel));
                seen_waits++;
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " select"}, 32'(slv_psel), 32'(e.sel));
                chk({e.tag, " error"}, 32'(mst_pslverr), 32'(e.err));
                chk({e.tag, " R3 wait count"}, 32'(seen_waits), 32'(e.waits));
                if (!e.wr) chk({e.tag, " read data"}, mst_prdata, e.rdata);
                chk("R4 address", slv_paddr, paddr);
                chk("R4 wdata", slv_pwdata, pwdata);
                chk("R4 write/enable", {30'd0, slv_pwrite, slv_penable}, {30'd0, pwrite, penable});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        for (int i = 0; i < NP; i++) exp_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 select in reset", 32'(slv_psel), 32'h0);
        @(posedge clk); #1;
        rst_n = 1;
        @(negedge clk);
        chk("R9 select after reset", 32'(slv_psel), 32'h0);

        xfer(32'h0010_0000, 1, 32'h1234_5678, 0, "R1 port1 write");
        xfer(32'h0010_0000, 0, 32'h0, 0, "R1 port1 read");
        xfer(32'h0050_0010, 1, 32'hCAFE_0001, 3, "R3 port5 write waits");
        xfer(32'h0050_0010, 0, 32'h0, 1, "R1 port5 read");
        xfer(32'h0000_0040, 1, 32'h0BAD_F00D, 2, "R2 port0 write");
        xfer(32'h0000_0040, 0, 32'h0, 0, "R2 port0 read");
        xfer(32'h0030_0000, 0, 32'h0, 0, "R5 port3 error read");
        xfer(32'h0030_0000, 1, 32'h5555_AAAA, 1, "R5 port3 error write");
        xfer(32'h0030_0000, 0, 32'h0, 0, "R5 port3 readback");
        xfer(32'h0060_0000, 0, 32'h0, 0, "R6 absent port6 read");
        xfer(32'h00F0_0000, 1, 32'hFFFF_FFFF, 2, "R6 absent portF write");
        xfer(32'h00A0_0000, 1, 32'h7777_7777, 0, "R6 absent portA write");
        xfer(32'h0010_0000, 0, 32'h0, 0, "R6 port1 untouched");
        xfer(32'hF140_0004, 1, 32'hABCD_0000, 0, "R7 high bits write");
        xfer(32'h0040_0008, 0, 32'h0, 2, "R7 low alias read");
        xfer(32'h0020_0000, 1, 32'h0246_8ACE, 0, "R8 port2 write");
        xfer(32'h0020_0000, 0, 32'h0, 0, "R8 port2 read");

        @(posedge clk); #1;
        paddr = 32'h0040_0000;
        @(negedge clk);
        chk("R8 idle data held", mst_prdata, 32'h0246_8ACE ^ pat(2));
        chk("R8 idle error held", 32'(mst_pslverr), 32'h0);
        chk("R2 idle select", 32'(slv_psel), 32'h0);
        @(posedge clk); #1;
        paddr = 32'h0090_0000;
        @(negedge clk);
        chk("R8 idle data after absent address", mst_prdata, 32'h0246_8ACE ^ pat(2));

        repeat (2) @(posedge clk);
        chk("queue drained", 32'(q.size()), 32'h0);
        summary();
    end
endmodule